// File: doc/BRIEF.md
# Timer Channel Compare/Capture Unit

This block is one 16-bit timer channel. It has a counter and four general registers, A to D, plus a shared start register and a control register. Registers A and B each drive or watch one pin. In compare mode a counter match on A or B drives its pin low, drives it high or toggles it. In capture mode a chosen pin edge copies the counter into A or B. Registers C and D can be set as buffers behind A and B. In compare mode the buffer loads its partner on a match. In capture mode the buffer takes its partner's previous value.

Software reaches all state through a word-wide register bus. A write lands on the next clock edge, and reads are combinational. The counter advances by one on each clock-enable pulse while the channel's start bit is set. When stopped, the counter and the pins hold their values. Writing the control register while stopped loads both pins with their programmed initial levels.

Top module: `tmr_channel`

Register map (word addresses on `busAddr`): 0 counter, 1 A, 2 B, 3 C, 4 D, 5 control, 7 start. Control register fields: bits [3:0] set pin A and bits [7:4] set pin B, each laid out as {capture, initLevel, act[1:0]}; bit 8 makes C the buffer of A, and bit 9 makes D the buffer of B. In compare mode, act 00 does nothing, 01 drives 0, 10 drives 1 and 11 toggles. In capture mode, act[0]=0 selects the rising edge and act[0]=1 the falling edge.

## Requirements
- R1: After reset the counter, A to D, the control register, the start register and both pin outputs are all 0.
- R2: While the channel's start bit is 1, the counter rises by one at every clock edge where `cntEn` is 1. It holds when `cntEn` is 0, and it wraps from 0xFFFF to 0x0000.
- R3: While the start bit is 0, the counter holds its value and both pin outputs keep their levels.
- R4: The start register stores bits 5..0 of a write and reads bits 15..6 as 0. The channel runs from bit `CH_IDX` (default 0).
- R5: In compare mode, a counting edge at which the counter equals A (or B) applies the act field to that pin at the same edge: 01 gives 0, 10 gives 1, 11 inverts the pin and 00 leaves it unchanged.
- R6: A control-register write while stopped sets each pin to its initLevel bit (bit 2 for A, bit 6 for B) at the write edge. A control-register write while running leaves the pins unchanged.
- R7: In capture mode, the selected edge seen on the pin input copies the current counter into A (or B) at the next clock edge. The other edge direction causes no capture.
- R8: When capture and buffering are both enabled, each capture also moves the previous A (or B) value into C (or D).
- R9: In compare mode with buffering enabled, a match on A (or B) loads C (or D) into A (or B).
- R10: If a capture and a bus write hit the same general register in the same cycle, the capture value is stored.
- R11: The counter and A to D take full 16-bit writes and read back the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count-enable pulse |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` |
| pinAIn | input | 1 | Capture input for register A |
| pinBIn | input | 1 | Capture input for register B |
| pinAOut | output | 1 | Compare output driven by register A |
| pinBOut | output | 1 | Compare output driven by register B |

## Verification
Bus writes and counter ticks land on the edge that ends their cycle. A compare match changes its pin at the same edge that moves the counter past the matching value. An edge on a capture pin is stored at the first clock edge that samples the new pin level. All inputs are driven just after a rising edge, and a scoreboard item is sampled at the following falling edge. A read check takes exactly one cycle and a pin check takes none, so every expected value is taken from a known count of edges after the stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_GRA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_IOC = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_STR = 3'd7;
  localparam int IOC_W = 10;

  typedef struct packed {
    logic       cntLoad;
    logic       cntTick;
    logic [3:0] grWr;
    logic [1:0] cap;
    logic [1:0] capShift;
    logic [1:0] cmpBuf;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int NUM_CH = 6,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  input  logic [1:0]        pinIn,
  input  logic [1:0]        cntEq,
  output tmrStrobe_t        strobe,
  output logic [IOC_W-1:0]  ioReg,
  output logic [NUM_CH-1:0] startReg,
  output logic [1:0]        pinOut
);
  logic       started;
  logic       ioWr;
  logic       strWr;
  logic [1:0] pinPrev;
  logic [1:0] match;
  logic [1:0] capEdge;
  logic [1:0] bufEn;

  assign started = startReg[CH_IDX];
  assign ioWr    = busWr && (busAddr == ADDR_IOC);
  assign strWr   = busWr && (busAddr == ADDR_STR);
  assign bufEn   = ioReg[9:8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioReg    <= '0;
      startReg <= '0;
      pinPrev  <= '0;
    end else begin
      pinPrev <= pinIn;
      if (ioWr)  ioReg    <= busWdata[IOC_W-1:0];
      if (strWr) startReg <= busWdata[NUM_CH-1:0];
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_pin
    logic       capMode;
    logic       initLvl;
    logic [1:0] act;
    assign capMode = ioReg[4*i+3];
    assign initLvl = ioReg[4*i+2];
    assign act     = ioReg[4*i+1 -: 2];

    assign match[i]   = !capMode && started && cntEn && cntEq[i];
    assign capEdge[i] = capMode && (act[0] ? (pinPrev[i] && !pinIn[i])
                                           : (pinIn[i] && !pinPrev[i]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinOut[i] <= 1'b0;
      end else if (ioWr && !started) begin
        pinOut[i] <= busWdata[4*i+2];
      end else if (match[i]) begin
        case (act)
          2'b01:   pinOut[i] <= 1'b0;
          2'b10:   pinOut[i] <= 1'b1;
          2'b11:   pinOut[i] <= !pinOut[i];
          default: pinOut[i] <= pinOut[i];
        endcase
      end
    end

    // R5
    toggle_act_chk: assert property (@(posedge clk) disable iff (!rstN)
      (match[i] && act == 2'b11 && !ioWr) |=> (pinOut[i] != $past(pinOut[i])));

    // R6
    init_force_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ioWr && !started) |=> (pinOut[i] == $past(busWdata[4*i+2])));

    // R8
    cap_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capShift[i]) |-> strobe.cap[i]);
  end

  always_comb begin
    strobe          = '0;
    strobe.cntLoad  = busWr && (busAddr == ADDR_CNT);
    strobe.cntTick  = started && cntEn && !strobe.cntLoad;
    for (int k = 0; k < 4; k++)
      strobe.grWr[k] = busWr && (busAddr == ADDR_GRA + ADDR_W'(k));
    strobe.cap      = capEdge;
    strobe.capShift = capEdge & bufEn;
    strobe.cmpBuf   = match & bufEn;
  end

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!started && !ioWr) |=> $stable(pinOut));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tmrStrobe_t            strobe,
  input  logic [WIDTH-1:0]      busWdata,
  output logic [WIDTH-1:0]      cnt,
  output logic [3:0][WIDTH-1:0] gr,
  output logic [1:0]            cntEq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntLoad) cnt <= busWdata;
    else if (strobe.cntTick) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < 2; i++) begin : g_pair
    assign cntEq[i] = (cnt == gr[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 gr[i] <= '0;
      else if (strobe.cap[i])    gr[i] <= cnt;
      else if (strobe.cmpBuf[i]) gr[i] <= gr[i+2];
      else if (strobe.grWr[i])   gr[i] <= busWdata;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   gr[i+2] <= '0;
      else if (strobe.capShift[i]) gr[i+2] <= gr[i];
      else if (strobe.grWr[i+2])   gr[i+2] <= busWdata;
    end

    // R7 R10
    cap_store_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.cap[i] |=> (gr[i] == $past(cnt)));

    // R8
    buf_move_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capShift[i] |=> (gr[i+2] == $past(gr[i])));

    // R9
    cmp_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.cmpBuf[i] && !strobe.cap[i]) |=> (gr[i] == $past(gr[i+2])));
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntTick |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int NUM_CH = 6,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic              pinAIn,
  input  logic              pinBIn,
  output logic              pinAOut,
  output logic              pinBOut
);
  tmrStrobe_t            strobe;
  logic [WIDTH-1:0]      cnt;
  logic [3:0][WIDTH-1:0] gr;
  logic [1:0]            cntEq;
  logic [IOC_W-1:0]      ioReg;
  logic [NUM_CH-1:0]     startReg;
  logic [1:0]            pinOut;

  tmr_ctrl #(.WIDTH(WIDTH), .NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .pinIn({pinBIn, pinAIn}), .cntEq(cntEq),
    .strobe(strobe), .ioReg(ioReg), .startReg(startReg), .pinOut(pinOut)
  );

  tmr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .cnt(cnt), .gr(gr), .cntEq(cntEq)
  );

  assign pinAOut = pinOut[0];
  assign pinBOut = pinOut[1];

  always_comb begin
    case (busAddr)
      3'd0:    busRdata = cnt;
      3'd1:    busRdata = gr[0];
      3'd2:    busRdata = gr[1];
      3'd3:    busRdata = gr[2];
      3'd4:    busRdata = gr[3];
      3'd5:    busRdata = {{(WIDTH-IOC_W){1'b0}}, ioReg};
      3'd7:    busRdata = {{(WIDTH-NUM_CH){1'b0}}, startReg};
      default: busRdata = '0;
    endcase
  end
endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b1;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        pinAIn = 1'b0;
  logic        pinBIn = 1'b0;
  logic        pinAOut;
  logic        pinBOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    bit          isPin;
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = !clk;

  tmr_channel uut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinAIn(pinAIn), .pinBIn(pinBIn),
    .pinAOut(pinAOut), .pinBOut(pinBOut)
  );

  // Monitor: pops scoreboard items at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      if (it.isPin) act = {15'd0, (it.sel == 0) ? pinAOut : pinBOut};
      else          act = busRdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    tick(1);
    busWr = 1'b0;
  endtask

  // consumes exactly one cycle
  task automatic expReg(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    busAddr = a;
    it.isPin = 0; it.sel = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    tick(1);
  endtask

  // consumes no cycle
  task automatic expPin(input int s, input logic e, input string tag);
    item_t it;
    it.isPin = 1; it.sel = s; it.exp = {15'd0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) expReg(3'(a), 16'h0, "R1");
    expPin(0, 1'b0, "R1");
    expPin(1, 1'b0, "R1");
    tick(1);

    // R11 read/write of counter and general registers
    wr(3'd1, 16'hA5A5); wr(3'd2, 16'h5A5A); wr(3'd3, 16'hFFFF); wr(3'd4, 16'h0001);
    wr(3'd0, 16'h1234);
    expReg(3'd1, 16'hA5A5, "R11"); expReg(3'd2, 16'h5A5A, "R11");
    expReg(3'd3, 16'hFFFF, "R11"); expReg(3'd4, 16'h0001, "R11");
    expReg(3'd0, 16'h1234, "R11");

    // R4 reserved start bits; R3 hold when own bit clear
    wr(3'd7, 16'h00FF);
    expReg(3'd7, 16'h003F, "R4");
    wr(3'd7, 16'h003E);
    wr(3'd0, 16'h1234);
    tick(3);
    expReg(3'd0, 16'h1234, "R3");

    // R2 counting, cntEn gating
    wr(3'd7, 16'h0001);
    expReg(3'd0, 16'h1234, "R2");
    expReg(3'd0, 16'h1235, "R2");
    cntEn = 1'b0;
    expReg(3'd0, 16'h1236, "R2");
    expReg(3'd0, 16'h1236, "R2");
    cntEn = 1'b1;
    wr(3'd7, 16'h0000);
    // R2 wrap
    wr(3'd0, 16'hFFFF);
    wr(3'd7, 16'h0001);
    expReg(3'd0, 16'hFFFF, "R2");
    expReg(3'd0, 16'h0000, "R2");
    wr(3'd7, 16'h0000);

    // R5 drive-1 action; R6 init forced while stopped
    wr(3'd5, 16'h0006);          // A: compare, init 1, drive1
    expPin(0, 1'b1, "R6");
    wr(3'd5, 16'h0002);          // A: compare, init 0, drive1
    expPin(0, 1'b0, "R6");
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'h000D);
    wr(3'd7, 16'h0001);
    tick(3);
    expPin(0, 1'b0, "R5");
    tick(1);
    expPin(0, 1'b1, "R5");
    wr(3'd7, 16'h0000);

    // R5 toggle
    wr(3'd5, 16'h0007);          // toggle, init 1
    expPin(0, 1'b1, "R6");
    wr(3'd0, 16'h0020);
    wr(3'd1, 16'h0021);
    wr(3'd7, 16'h0001);
    tick(1);
    expPin(0, 1'b1, "R5");
    tick(1);
    expPin(0, 1'b0, "R5");
    // R6 running write leaves pin
    wr(3'd5, 16'h0004);
    expPin(0, 1'b0, "R6");
    wr(3'd7, 16'h0000);
    tick(3);
    // R3 pin kept after stop
    expPin(0, 1'b0, "R3");
    tick(1);

    // R5 drive-0 action
    wr(3'd5, 16'h0005);          // drive0, init 1
    wr(3'd0, 16'h0040);
    wr(3'd1, 16'h0041);
    wr(3'd7, 16'h0001);
    tick(1);
    expPin(0, 1'b1, "R5");
    tick(1);
    expPin(0, 1'b0, "R5");
    wr(3'd7, 16'h0000);

    // R9 compare buffer reload
    wr(3'd5, 16'h0103);          // bufA, toggle, init 0
    wr(3'd0, 16'h0050);
    wr(3'd1, 16'h0051);
    wr(3'd3, 16'h0060);
    wr(3'd7, 16'h0001);
    tick(2);
    wr(3'd7, 16'h0000);
    expReg(3'd1, 16'h0060, "R9");
    expPin(0, 1'b1, "R9");
    tick(1);

    // R7 capture rising on B (stopped)
    wr(3'd5, 16'h0080);
    wr(3'd0, 16'h0100);
    pinBIn = 1'b1;
    tick(1);
    expReg(3'd2, 16'h0100, "R7");
    // R7 falling selected: rising level held gives no capture, fall captures
    wr(3'd5, 16'h0090);
    wr(3'd0, 16'h0200);
    expReg(3'd2, 16'h0100, "R7");
    pinBIn = 1'b0;
    tick(1);
    expReg(3'd2, 16'h0200, "R7");

    // R8 capture with buffer
    wr(3'd5, 16'h0280);
    wr(3'd0, 16'h0300);
    pinBIn = 1'b1;
    tick(1);
    expReg(3'd2, 16'h0300, "R8");
    expReg(3'd4, 16'h0200, "R8");

    // R10 capture beats same-cycle bus write
    pinBIn = 1'b0;
    wr(3'd0, 16'h0400);
    busWr = 1'b1; busAddr = 3'd2; busWdata = 16'hBEEF; pinBIn = 1'b1;
    tick(1);
    busWr = 1'b0;
    expReg(3'd2, 16'h0400, "R10");
    expReg(3'd4, 16'h0300, "R10");

    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule